// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B. Each direction has its own capture register with its own capture clock. The A-side register samples bus A and the B-side register samples bus B, each on the rising edge of its clock. For each direction, a select input picks what goes onto the far bus. It is either the live value of the near bus or the value last captured from it. A separate enable decides whether the far side is driven at all.

Tri-state pins are modelled as three signals per bus: an input, an output value and an output enable. A pad ring or a test harness combines them into a real bidirectional pin. The B-side enable is active-high and the A-side enable is active-low. Both may be asserted together, so that the stored words travel in both directions at once.

A build parameter makes the data path inverting. The inversion applies to both directions, and to both the live and the stored routes. The registers have no reset. Everything after the registers is combinational.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: On a rising edge of `clkCapA` the A-side register loads `aIn`, and on a rising edge of `clkCapB` the B-side register loads `bIn`. Each clock leaves the other register unchanged.
- R2: Between rising edges of its own clock, a register keeps its value whatever its bus input does.
- R3: With `selStoredAB` = 0, `bOut` carries the live `aIn` (after the polarity option). With `selStoredAB` = 1, it carries the A-side register.
- R4: With `selStoredBA` = 0, `aOut` carries the live `bIn` (after the polarity option). With `selStoredBA` = 1, it carries the B-side register.
- R5: `bOe` equals `enDriveB`, which is active-high: 1 drives bus B and 0 releases it.
- R6: `aOe` equals the inverse of `enDriveAN`, which is active-low: 0 drives bus A and 1 releases it.
- R7: With `enDriveB` = 1, `enDriveAN` = 0 and both selects at 1, both outputs are driven at once, each with its stored word.
- R8: With `INVERT` = 1, every output bit is the complement of its source bit, for both directions and for both the live and stored routes. With `INVERT` = 0, no bit is inverted.
- R9: A change on a select, an enable or a live bus input reaches the outputs without any capture-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkCapA | input | 1 | Rising edge loads `aIn` into the A-side register |
| clkCapB | input | 1 | Rising edge loads `bIn` into the B-side register |
| selStoredAB | input | 1 | Source for bus B: 0 = live A, 1 = stored A |
| selStoredBA | input | 1 | Source for bus A: 0 = live B, 1 = stored B |
| enDriveB | input | 1 | Active-high output enable toward bus B |
| enDriveAN | input | 1 | Active-low output enable toward bus A |
| aIn | input | WIDTH | Value seen on bus A |
| aOut | output | WIDTH | Value to drive onto bus A |
| aOe | output | 1 | Drive bus A when 1, release it when 0 |
| bIn | input | WIDTH | Value seen on bus B |
| bOut | output | WIDTH | Value to drive onto bus B |
| bOe | output | 1 | Drive bus B when 1, release it when 0 |

## Verification
The bench builds two copies side by side, both 8 bits wide. One copy has `INVERT` = 0 and the other has `INVERT` = 1, and both receive the same stimulus. Each expected value therefore has a true form and a complemented form, which exposes a polarity fault on any single route. Preloading the registers with words that differ from every later live value lets a check tell the stored route from the live route, and shows whether a clock disturbed the register of the other direction.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Decoded steering strobes from the control unit to the datapath.
  typedef struct packed {
    logic useStoredToB;
    logic useStoredToA;
    logic driveB;
    logic driveA;
  } xcvr_ctrl_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic       selStoredAB,
  input  logic       selStoredBA,
  input  logic       enDriveB,
  input  logic       enDriveAN,
  output xcvr_ctrl_t ctrl
);
  always_comb begin
    ctrl.useStoredToB = selStoredAB;
    ctrl.useStoredToA = selStoredBA;
    ctrl.driveB       = enDriveB;
    ctrl.driveA       = ~enDriveAN;
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
)(
  input  logic             clkCapA,
  input  logic             clkCapB,
  input  xcvr_ctrl_t       ctrl,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe,
  output logic [WIDTH-1:0] heldA,
  output logic [WIDTH-1:0] heldB
);
  localparam logic [WIDTH-1:0] POL_MASK = INVERT ? {WIDTH{1'b1}} : '0;

  logic [WIDTH-1:0] srcToB;
  logic [WIDTH-1:0] srcToA;

  // Capture registers, no reset: contents persist while the clock idles.
  always_ff @(posedge clkCapA) heldA <= aIn;
  always_ff @(posedge clkCapB) heldB <= bIn;

  always_comb begin
    srcToB = ctrl.useStoredToB ? heldA : aIn;
    srcToA = ctrl.useStoredToA ? heldB : bIn;
  end

  generate
    if (INVERT) begin : g_inv
      always_comb begin
        bOut = srcToB ^ POL_MASK;
        aOut = srcToA ^ POL_MASK;
      end
    end else begin : g_true
      always_comb begin
        bOut = srcToB;
        aOut = srcToA;
      end
    end
  endgenerate

  assign bOe = ctrl.driveB;
  assign aOe = ctrl.driveA;
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
)(
  input  logic             clkCapA,
  input  logic             clkCapB,
  input  logic             selStoredAB,
  input  logic             selStoredBA,
  input  logic             enDriveB,
  input  logic             enDriveAN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);
  xcvr_ctrl_t       ctrl;
  logic [WIDTH-1:0] heldA;
  logic [WIDTH-1:0] heldB;

  xcvr_ctrl u_ctrl (
    .selStoredAB(selStoredAB),
    .selStoredBA(selStoredBA),
    .enDriveB   (enDriveB),
    .enDriveAN  (enDriveAN),
    .ctrl       (ctrl)
  );

  xcvr_datapath #(.WIDTH(WIDTH), .INVERT(INVERT)) u_dp (
    .clkCapA(clkCapA),
    .clkCapB(clkCapB),
    .ctrl   (ctrl),
    .aIn    (aIn),
    .bIn    (bIn),
    .aOut   (aOut),
    .aOe    (aOe),
    .bOut   (bOut),
    .bOe    (bOe),
    .heldA  (heldA),
    .heldB  (heldB)
  );
endmodule

// File: rtl/bidir_reg_xcvr_chk.sv
module bidir_reg_xcvr_chk #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
)(
  input logic             clkCapA,
  input logic             clkCapB,
  input logic             selStoredAB,
  input logic             selStoredBA,
  input logic             enDriveB,
  input logic             enDriveAN,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aOut,
  input logic             aOe,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] bOut,
  input logic             bOe
);
  localparam logic [WIDTH-1:0] POL_MASK = INVERT ? {WIDTH{1'b1}} : '0;

  // Warm-up counters stand in for a reset: checks start once a capture is known.
  logic [1:0] warmA = 2'd0;
  logic [1:0] warmB = 2'd0;
  always_ff @(posedge clkCapA) if (warmA != 2'd2) warmA <= warmA + 2'd1;
  always_ff @(posedge clkCapB) if (warmB != 2'd2) warmB <= warmB + 2'd1;

  // R1, R3: stored route shows the word captured on the previous A edge
  p_stored_to_b_r3: assert property (@(posedge clkCapA) disable iff (warmA != 2'd2)
    selStoredAB |-> (bOut == ($past(aIn) ^ POL_MASK)));
  // R1, R4
  p_stored_to_a_r4: assert property (@(posedge clkCapB) disable iff (warmB != 2'd2)
    selStoredBA |-> (aOut == ($past(bIn) ^ POL_MASK)));
  // R3, R8: live route
  p_live_to_b_r3: assert property (@(posedge clkCapA) disable iff (warmA != 2'd2)
    !selStoredAB |-> (bOut == (aIn ^ POL_MASK)));
  p_live_to_a_r4: assert property (@(posedge clkCapB) disable iff (warmB != 2'd2)
    !selStoredBA |-> (aOut == (bIn ^ POL_MASK)));
  // R5
  p_enable_b_r5: assert property (@(posedge clkCapA) disable iff (warmA != 2'd2)
    bOe == enDriveB);
  // R6
  p_enable_a_r6: assert property (@(posedge clkCapB) disable iff (warmB != 2'd2)
    aOe == !enDriveAN);
endmodule

bind bidir_reg_xcvr bidir_reg_xcvr_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) chk_i (
  .clkCapA(clkCapA), .clkCapB(clkCapB),
  .selStoredAB(selStoredAB), .selStoredBA(selStoredBA),
  .enDriveB(enDriveB), .enDriveAN(enDriveAN),
  .aIn(aIn), .aOut(aOut), .aOe(aOe),
  .bIn(bIn), .bOut(bOut), .bOe(bOe)
);

// File: tb/bidir_reg_xcvr_tb_top.sv
module bidir_reg_xcvr_tb_top;
  localparam int W = 8;
  localparam int NVEC = 8;

  logic sysClk = 1'b0;
  always #2.5 sysClk = ~sysClk;

  logic clkCapA = 0, clkCapB = 0;
  logic selStoredAB = 0, selStoredBA = 0, enDriveB = 0, enDriveAN = 1;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, bOut, aOutI, bOutI;
  logic aOe, bOe, aOeI, bOeI;

  int compared = 0;
  int mismatched = 0;

  bidir_reg_xcvr #(.WIDTH(W), .INVERT(1'b0)) dut_i (
    .clkCapA, .clkCapB, .selStoredAB, .selStoredBA, .enDriveB, .enDriveAN,
    .aIn, .aOut(aOut), .aOe(aOe), .bIn, .bOut(bOut), .bOe(bOe));

  bidir_reg_xcvr #(.WIDTH(W), .INVERT(1'b1)) dutInv_i (
    .clkCapA, .clkCapB, .selStoredAB, .selStoredBA, .enDriveB, .enDriveAN,
    .aIn, .aOut(aOutI), .aOe(aOeI), .bIn, .bOut(bOutI), .bOe(bOeI));

  // {selAB, selBA, enB, enAN, aIn, bIn, expB, expBOe, expA, expAOe}
  // Expected values are for the non-inverting copy; the register holds 3C (A) and A5 (B).
  typedef struct packed {
    logic sAB; logic sBA; logic eB; logic eAN;
    logic [7:0] a; logic [7:0] b;
    logic [7:0] xB; logic xBOe; logic [7:0] xA; logic xAOe;
  } vec_t;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,1'b1,1'b0,8'h11,8'h22,8'h11,1'b1,8'h22,1'b1},
    '{1'b1,1'b0,1'b1,1'b0,8'h11,8'h22,8'h3C,1'b1,8'h22,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,8'h44,8'h55,8'h44,1'b1,8'hA5,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'hFF,8'h3C,1'b1,8'hA5,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,8'h66,8'h77,8'h66,1'b0,8'h77,1'b0},
    '{1'b1,1'b1,1'b0,1'b1,8'hFF,8'h00,8'h3C,1'b0,8'hA5,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,8'h80,8'h01,8'h80,1'b1,8'h01,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,8'h7E,8'hE7,8'h7E,1'b0,8'hE7,1'b1}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Checks both copies: the inverting one must show the complement.
  task automatic chkOuts(input string req, input logic [7:0] xB, input logic xBOe,
                         input logic [7:0] xA, input logic xAOe);
    chk({req, " bOut"}, bOut, xB);
    chk({req, " aOut"}, aOut, xA);
    chk({req, " bOe R5"}, {7'd0, bOe}, {7'd0, xBOe});
    chk({req, " aOe R6"}, {7'd0, aOe}, {7'd0, xAOe});
    chk({req, " inv bOut R8"}, bOutI, ~xB);
    chk({req, " inv aOut R8"}, aOutI, ~xA);
    chk({req, " inv oe R8"}, {6'd0, bOeI, aOeI}, {6'd0, xBOe, xAOe});
  endtask

  task automatic pulseA();
    @(negedge sysClk); clkCapA = 1; @(negedge sysClk); clkCapA = 0; @(negedge sysClk);
  endtask
  task automatic pulseB();
    @(negedge sysClk); clkCapB = 1; @(negedge sysClk); clkCapB = 0; @(negedge sysClk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge sysClk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    // Warm the checkers and preload known words (R1).
    aIn = 8'h5A; bIn = 8'hC3; pulseA(); pulseB();
    aIn = 8'h3C; pulseA();
    bIn = 8'hA5; pulseB();
    // Start-up state after preload: stored words visible on both routes (R1, R7).
    selStoredAB = 1; selStoredBA = 1; enDriveB = 1; enDriveAN = 0;
    aIn = 8'h00; bIn = 8'h00; #1;
    chkOuts("R1 R7 preload", 8'h3C, 1'b1, 8'hA5, 1'b1);

    // Table walk, capture clocks idle (R2, R3, R4, R9).
    for (int i = 0; i < NVEC; i++) begin
      @(negedge sysClk);
      selStoredAB = VECS[i].sAB; selStoredBA = VECS[i].sBA;
      enDriveB = VECS[i].eB; enDriveAN = VECS[i].eAN;
      aIn = VECS[i].a; bIn = VECS[i].b;
      #1;
      chkOuts($sformatf("R3 R4 R2 vec%0d", i), VECS[i].xB, VECS[i].xBOe, VECS[i].xA, VECS[i].xAOe);
    end

    // R1: A clock alone changes only the A register.
    selStoredAB = 1; selStoredBA = 1; enDriveB = 1; enDriveAN = 0;
    aIn = 8'hC3; bIn = 8'h0F; pulseA();
    aIn = 8'h00; #1;
    chkOuts("R1 A-only capture", 8'hC3, 1'b1, 8'hA5, 1'b1);
    // R1: B clock alone changes only the B register.
    bIn = 8'h96; pulseB();
    bIn = 8'h00; #1;
    chkOuts("R1 B-only capture", 8'hC3, 1'b1, 8'h96, 1'b1);

    // R2: live input toggling without an edge leaves stored words intact.
    @(negedge sysClk); aIn = 8'hFF; bIn = 8'hFF; #1;
    chkOuts("R2 hold", 8'hC3, 1'b1, 8'h96, 1'b1);

    // R9: switching select with no clock moves the output at once.
    @(negedge sysClk); selStoredAB = 0; #1;
    chk("R9 sel immediate bOut", bOut, 8'hFF);
    selStoredBA = 0; bIn = 8'h24; #1;
    chk("R9 live change aOut", aOut, 8'h24);
    enDriveAN = 1; #1;
    chk("R9 R6 enable immediate", {7'd0, aOe}, 8'd0);
    enDriveB = 0; #1;
    chk("R9 R5 enable immediate", {7'd0, bOe}, 8'd0);

    // R8: bit pattern with mixed bits on both routes of the inverting copy.
    selStoredAB = 1; #1;
    chk("R8 inv stored bOut", bOutI, 8'h3C);
    chk("R8 true stored bOut", bOut, 8'hC3);

    repeat (4) @(negedge sysClk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule